// File: doc/BRIEF.md
# Serial Multi-Level Cell Read Sequencer

This block turns one read of a two-bit resistive storage cell into its two-bit symbol. The cell holds one of four resistance levels. The analog sense path compares the cell against one reference at a time. The sequencer chooses which reference the comparator sees in each cycle. It then reads back a single "cell is below this reference" bit, and from the order of those answers it decides the symbol. The analog sense path itself is outside this block.

Symbol 11 is the lowest-resistance level, fully crystalline. Symbol 00 is the highest-resistance level, fully amorphous. Symbols 10 and 01 are the intermediate levels. References are applied from the lowest threshold upward, and the read stops as soon as the cell reads below the current one.

The thresholds between 11/10 and between 10/01 are fixed; the 10/01 threshold sits midway between those two levels. The threshold between 01 and 00 can be retuned. It is taken from a small bank of options, and a tuning lookup picks one from the block's two-bit storage-age tag and two-bit programming-cycle bucket. Longer storage pushes the choice up the bank. More wear pulls it down.

The FSM states are:
- `ST_IDLE`: waiting for a start.
- `ST_LO`: compare against the 11/10 threshold.
- `ST_MID`: compare against the 10/01 threshold.
- `ST_HI`: compare against the tuned 01/00 threshold.
- `ST_DONE`: result cycle.

The transitions are:
- `ST_IDLE` to `ST_LO` on start.
- `ST_LO` to `ST_DONE` when the cell is below, otherwise `ST_LO` to `ST_MID`.
- `ST_MID` to `ST_DONE` when the cell is below, otherwise `ST_MID` to `ST_HI`.
- `ST_HI` to `ST_DONE` always.
- `ST_DONE` to `ST_IDLE` always.

Top module: `mlc_level_sense`

## Requirements
- R1: After reset, `ref_sel` is 0, `done` is 0 and `symbol` is 00.
- R2: A start sampled in idle makes `ref_sel` equal to 1 (the 11/10 threshold) in the next cycle. Each compare step lasts one cycle. The step after code 1 uses code 2 (the 10/01 threshold), and the step after that uses code 3+k, where k is the tuned option index for the 01/00 threshold.
- R3: If `cmp_below` is 1 during the code-1 step, the next cycle shows `done`=1 with symbol 11, and no further reference is applied.
- R4: If the cell is not below code 1 but is below code 2, the result is symbol 10 after the code-2 step.
- R5: During the tuned step, `cmp_below`=1 yields symbol 01 and `cmp_below`=0 yields symbol 00, reported in the following cycle.
- R6: `done` is high for exactly one cycle. `ref_sel` is 0 in that cycle and while idle, and `symbol` holds its value until the next result.
- R7: The tuned option k equals floor((age + (3 - cyc) + 1) / 2), where age and cyc are the 2-bit inputs read as unsigned numbers. The result saturates to NUM_OPT-1, which is 2 at the default of three options.
- R8: The age tag and cycle bucket are sampled only with an accepted start. Changes to them during a read do not alter `ref_sel`.
- R9: A start is accepted only in idle. A start during compare steps or during the `done` cycle is ignored, and the block returns to idle with `ref_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one read (accepted in idle only) |
| cmp_below | input | 1 | Cell reads below the reference chosen by `ref_sel` this cycle |
| age_tag | input | 2 | Storage-age bucket of the block being read |
| cyc_bkt | input | 2 | Coarse programming-cycle bucket |
| ref_sel | output | 3 | 0 none, 1 threshold 11/10, 2 threshold 10/01, 3+k tuned 01/00 option k |
| symbol | output | 2 | Decided two-bit symbol, held until the next result |
| done | output | 1 | One-cycle pulse marking a new valid symbol |

## Verification
The assertions cover the cycle-level protocol on every clock:
- `done` lasts a single cycle.
- An accepted start leads straight to the lowest reference.
- An early stop at the first step reports 11.
- The tuned code stays inside the option bank.
- The latched option does not move mid-read.

The decoded symbol for each of the four levels, the exact tuning value for all sixteen age/cycle pairs, and the rejection of stray starts and mid-read tag changes are shown only by the bench scenarios. In those scenarios a behavioural cell model answers the comparator for each reference.

// File: rtl/mlc_sense_pkg.sv
package mlc_sense_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LO   = 3'd1,
        ST_MID  = 3'd2,
        ST_HI   = 3'd3,
        ST_DONE = 3'd4
    } sense_st_e;

    localparam logic [1:0] SYM_AMORPH = 2'b00;
    localparam logic [1:0] SYM_UPPER  = 2'b01;
    localparam logic [1:0] SYM_LOWER  = 2'b10;
    localparam logic [1:0] SYM_CRYST  = 2'b11;

    // Raw option index before saturation: (age + (3-cyc) + 1) / 2
    function automatic logic [1:0] tune_raw(input logic [1:0] age, input logic [1:0] cyc);
        logic [2:0] sum;
        sum = {1'b0, age} + {1'b0, ~cyc} + 3'd1;
        return sum[2:1];
    endfunction

endpackage

// File: rtl/mlc_ref_tuner.sv
module mlc_ref_tuner #(
    parameter int NUM_OPT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       busy,
    input  logic [1:0] age_tag,
    input  logic [1:0] cyc_bkt,
    output logic [1:0] opt_q
);
    import mlc_sense_pkg::*;

    localparam logic [1:0] TOP_OPT = 2'(NUM_OPT - 1);

    logic [1:0] raw;
    logic [1:0] opt_d;

    always_comb begin
        raw   = tune_raw(age_tag, cyc_bkt);
        opt_d = (raw > TOP_OPT) ? TOP_OPT : raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    opt_q <= '0;
        else if (load) opt_q <= opt_d;
    end

    // R8
    opt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(opt_q));

    // R7
    opt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        opt_q <= TOP_OPT);

endmodule

// File: rtl/mlc_sense_fsm.sv
module mlc_sense_fsm (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cmp_below,
    output mlc_sense_pkg::sense_st_e state_q,
    output logic [1:0]               symbol,
    output logic                     done
);
    import mlc_sense_pkg::*;

    sense_st_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LO;
            ST_LO:   state_d = cmp_below ? ST_DONE : ST_MID;
            ST_MID:  state_d = cmp_below ? ST_DONE : ST_HI;
            ST_HI:   state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            symbol <= SYM_AMORPH;
            done   <= 1'b0;
        end else begin
            done <= (state_d == ST_DONE);
            unique case (state_q)
                ST_LO:   if (cmp_below) symbol <= SYM_CRYST;
                ST_MID:  if (cmp_below) symbol <= SYM_LOWER;
                ST_HI:   symbol <= cmp_below ? SYM_UPPER : SYM_AMORPH;
                default: ;
            endcase
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mlc_ref_mux.sv
module mlc_ref_mux #(
    parameter int NUM_OPT = 3,
    parameter int REF_W   = 3
) (
    input  mlc_sense_pkg::sense_st_e state,
    input  logic [1:0]               opt,
    output logic [REF_W-1:0]         ref_sel
);
    import mlc_sense_pkg::*;

    localparam logic [REF_W-1:0] TUNE_BASE = REF_W'(3);

    always_comb begin
        unique case (state)
            ST_LO:   ref_sel = REF_W'(1);
            ST_MID:  ref_sel = REF_W'(2);
            ST_HI:   ref_sel = TUNE_BASE + REF_W'(opt);
            default: ref_sel = '0;
        endcase
    end

endmodule

// File: rtl/mlc_level_sense.sv
module mlc_level_sense #(
    parameter int NUM_OPT = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       cmp_below,
    input  logic [1:0] age_tag,
    input  logic [1:0] cyc_bkt,
    output logic [2:0] ref_sel,
    output logic [1:0] symbol,
    output logic       done
);
    import mlc_sense_pkg::*;

    localparam int REF_W = 3;

    sense_st_e  state;
    logic [1:0] opt;
    logic       busy;
    logic       accept;

    assign busy   = (state != ST_IDLE);
    assign accept = start && !busy;

    mlc_sense_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cmp_below (cmp_below),
        .state_q   (state),
        .symbol    (symbol),
        .done      (done)
    );

    mlc_ref_tuner #(.NUM_OPT(NUM_OPT)) u_tuner (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .busy    (busy),
        .age_tag (age_tag),
        .cyc_bkt (cyc_bkt),
        .opt_q   (opt)
    );

    mlc_ref_mux #(.NUM_OPT(NUM_OPT), .REF_W(REF_W)) u_mux (
        .state   (state),
        .opt     (opt),
        .ref_sel (ref_sel)
    );

    // R2
    first_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ref_sel == 3'd1));

    // R2
    tuned_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel >= 3'd3) |-> (ref_sel < 3'(3 + NUM_OPT)));

    // R3
    early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(ref_sel) == 3'd1) |-> (symbol == 2'b11));

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ref_sel == 3'd0));

endmodule

// File: tb/tb_mlc_level_sense.sv
`timescale 1ns/1ps
module tb_mlc_level_sense;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cmp_below;
    logic [1:0] age_tag = '0;
    logic [1:0] cyc_bkt = '0;
    logic [2:0] ref_sel;
    logic [1:0] symbol;
    logic       done;
    logic [1:0] cell_sym = 2'b00;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    mlc_level_sense dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_below(cmp_below),
        .age_tag(age_tag), .cyc_bkt(cyc_bkt),
        .ref_sel(ref_sel), .symbol(symbol), .done(done)
    );

    // Cell model: 11 < ref1 < 10 < ref2 < 01 < tuned ref < 00
    always_comb begin
        cmp_below = 1'b0;
        if (ref_sel == 3'd1)      cmp_below = (cell_sym == 2'b11);
        else if (ref_sel == 3'd2) cmp_below = (cell_sym == 2'b11) || (cell_sym == 2'b10);
        else if (ref_sel >= 3'd3) cmp_below = (cell_sym != 2'b00);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_opt(input int age, input int cyc);
        int r;
        r = (age + (3 - cyc) + 1) / 2;
        return (r > 2) ? 2 : r;
    endfunction

    // One read; disturb = change tags and pulse start during the read (R8, R9)
    task automatic do_read(input logic [1:0] sym, input logic [1:0] age,
                           input logic [1:0] cyc, input bit disturb);
        int n;
        int k;
        n = (sym == 2'b11) ? 1 : (sym == 2'b10) ? 2 : 3;
        k = exp_opt(age, cyc);
        @(negedge clk);
        cell_sym = sym; age_tag = age; cyc_bkt = cyc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 1; i <= n; i++) begin
            chk(ref_sel == 3'((i < 3) ? i : 3 + k), (i == 3) ? "R7 tuned ref" : "R2 step ref",
                ref_sel, (i < 3) ? i : 3 + k);
            chk(!done, "R2 no done mid-read", done, 0);
            if (disturb) begin
                age_tag = ~age; cyc_bkt = ~cyc; start = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
        end
        chk(done, "R6 done pulse", done, 1);
        chk(symbol == sym, (sym == 2'b11) ? "R3 symbol" : (sym == 2'b10) ? "R4 symbol" : "R5 symbol",
            symbol, sym);
        chk(ref_sel == 3'd0, "R6 ref idle at done", ref_sel, 0);
        if (disturb) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R6 done one cycle", done, 0);
        chk(ref_sel == 3'd0, disturb ? "R9 no restart" : "R6 idle ref", ref_sel, 0);
        chk(symbol == sym, "R6 symbol held", symbol, sym);
    endtask

    task automatic test_reset();
        #1;
        chk(ref_sel == 3'd0, "R1 ref_sel", ref_sel, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(symbol == 2'b00, "R1 symbol", symbol, 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic test_levels();
        do_read(2'b11, 2'd1, 2'd1, 0);
        do_read(2'b10, 2'd1, 2'd1, 0);
        do_read(2'b01, 2'd1, 2'd1, 0);
        do_read(2'b00, 2'd1, 2'd1, 0);
    endtask

    task automatic test_tuning_sweep();
        for (int a = 0; a < 4; a++)
            for (int c = 0; c < 4; c++)
                do_read(2'b00, 2'(a), 2'(c), 0);
    endtask

    task automatic test_disturb();
        do_read(2'b00, 2'd3, 2'd0, 1);
        do_read(2'b01, 2'd0, 2'd3, 1);
        do_read(2'b11, 2'd2, 2'd2, 1);
    endtask

    initial begin
        test_reset();
        test_levels();
        test_tuning_sweep();
        test_disturb();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule